// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Flags

This block turns a serial input line into bytes. A clock-enable pulse runs at sixteen times the bit rate, and the block uses it to time each bit. A falling edge on the idle-high line starts a frame. The block checks the start bit again at its middle. It then takes eight data bits, least significant first, and judges the stop bit. A good byte goes into a data register and raises a "data ready" flag.

Two error flags record problems. The first is a byte that arrives while the previous one is still unread. The second is a stop bit sampled low. While either error flag is set, the receiver takes no new frame.

Software reaches the block through a one-cycle register port with two addresses: data and status. A read of the data register clears the ready flag. An error flag clears only through a two-step handshake: a status read that sees the flag set, then a write of 0 to that bit. A configuration input selects one or two stop bits. A receive-enable input gates reception.

Top module: `async_rx_stat`

## Requirements
- R1: After reset, the status register (address 1) reads 0x00 and the data register (address 0) reads 0x00.
- R2: A low level on the idle line starts a frame only if the line is still low at the middle of the start bit (sample 8 of 16). A shorter low pulse returns the receiver to idle, and nothing is received.
- R3: Data bits are sampled at mid-bit, least significant bit first, eight per frame. A frame whose first stop bit is 1 loads the byte into the data register and sets status bit 0 (data ready), provided data ready was 0.
- R4: A read of the data register (address 0) clears data ready.
- R5: When a frame completes with a good stop bit while data ready is 1, status bit 1 (overrun) is set. The data register keeps the earlier byte, and the new byte is discarded.
- R6: When the first stop bit is sampled 0, status bit 2 (framing) is set. The byte is still written to the data register, but data ready is not raised.
- R7: With two-stop mode selected, only the first stop bit is judged. A low second stop bit causes no error and does not start a new frame.
- R8: While the overrun or framing flag is 1, no new frame is accepted, and the data register and data ready do not change because of line activity.
- R9: An error flag clears only on a write to address 1 with a 0 in its bit, made after a status read that returned that bit as 1. The read-seen condition is kept per flag and is reset when the flag clears, so a flag that sets again needs a new read before it can clear.
- R10: Writes of 1 to status bits have no effect, and writes to the status register never change data ready.
- R11: While receive enable is 0, no frame is received. Taking receive enable low leaves the overrun and framing flags as they were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| os_tick | input | 1 | Oversampling enable, sixteen pulses per bit time |
| rx_line | input | 1 | Serial input line, idle high |
| rx_en | input | 1 | Receive enable |
| two_stop | input | 1 | 1 selects two stop bits, 0 selects one |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 1 | 0 selects data, 1 selects status |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data of the addressed register |

## Verification
The bench sends several kinds of frames: good frames, frames with a bad first stop bit, and frames with a low second stop bit. It checks both registers after each one. A design that judged the second stop bit, or that set data ready on a framing error, would show the wrong status byte.

The bench forces an overrun and confirms that the first byte survives. It then sends a frame while the lock is held. A design without the lock, or one that overwrote data on overrun, would expose the later byte.

The clear handshake is probed in three ways: by a write with no prior read, by a write after a read, and by a second overrun after a clear. A design with one shared "seen" bit, or one that never resets it, would clear a flag that should stay set. Further tests cover a start glitch shorter than half a bit, frames sent while reception is disabled, and writes of all ones.

// File: rtl/arx_pkg.sv
package arx_pkg;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_STOP1,
      RX_STOP2
   } rx_state_e;

   localparam logic ADDR_DATA = 1'b0;
   localparam logic ADDR_STAT = 1'b1;

   localparam int STAT_RDY_BIT = 0;
   localparam int STAT_OVR_BIT = 1;
   localparam int STAT_FRM_BIT = 2;

   localparam int ERR_OVR = 0;
   localparam int ERR_FRM = 1;
   localparam int ERR_CNT = 2;

endpackage

// File: rtl/arx_sync.sv
module arx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   generate
      if (STAGES == 0) begin : g_direct
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0] pipe_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q <= '1;
            else if (STAGES == 1) pipe_q <= din;
            else pipe_q <= {pipe_q[STAGES-2:0], din};
         end
         assign dout = pipe_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/arx_deframer.sv
module arx_deframer
   import arx_pkg::*;
#(
   parameter int OSR    = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              line,
   input  logic              enable,
   input  logic              lock,
   input  logic              two_stop,
   output logic              done,
   output logic              stop_ok,
   output logic [DATA_W-1:0] byte_o,
   output logic              busy
);

   localparam int CNT_W = $clog2(OSR);
   localparam int IDX_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OSR / 2 - 1);
   localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OSR - 1);
   localparam logic [IDX_W-1:0] BIT_LAST  = IDX_W'(DATA_W - 1);

   rx_state_e         state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [IDX_W-1:0]  idx_q;
   logic [DATA_W-1:0] shift_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RX_IDLE;
         cnt_q   <= '0;
         idx_q   <= '0;
         shift_q <= '0;
         done    <= 1'b0;
         stop_ok <= 1'b0;
         byte_o  <= '0;
      end else begin
         done <= 1'b0;
         if (!enable) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
         end else if (tick) begin
            unique case (state_q)
               RX_IDLE: begin
                  if (!line && !lock) begin
                     state_q <= RX_START;
                     cnt_q   <= '0;
                  end
               end
               RX_START: begin
                  if (cnt_q == HALF_LAST) begin
                     cnt_q <= '0;
                     idx_q <= '0;
                     state_q <= line ? RX_IDLE : RX_DATA;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               RX_DATA: begin
                  if (cnt_q == FULL_LAST) begin
                     cnt_q   <= '0;
                     shift_q <= {line, shift_q[DATA_W-1:1]};
                     if (idx_q == BIT_LAST) state_q <= RX_STOP1;
                     else idx_q <= idx_q + 1'b1;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               RX_STOP1: begin
                  if (cnt_q == FULL_LAST) begin
                     cnt_q   <= '0;
                     done    <= 1'b1;
                     stop_ok <= line;
                     byte_o  <= shift_q;
                     state_q <= two_stop ? RX_STOP2 : RX_IDLE;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               RX_STOP2: begin
                  if (cnt_q == FULL_LAST) begin
                     cnt_q   <= '0;
                     state_q <= RX_IDLE;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               default: state_q <= RX_IDLE;
            endcase
         end
      end
   end

   assign busy = (state_q != RX_IDLE);

endmodule

// File: rtl/arx_status.sv
module arx_status
   import arx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frm_done,
   input  logic               frm_ok,
   input  logic [DATA_W-1:0]  frm_byte,
   input  logic               rd_data,
   input  logic               rd_stat,
   input  logic               wr_stat,
   input  logic [ERR_CNT-1:0] wr_bits,
   output logic [DATA_W-1:0]  data_q,
   output logic               rdy_q,
   output logic [ERR_CNT-1:0] err_q
);

   logic [ERR_CNT-1:0] err_set;

   assign err_set[ERR_OVR] = frm_done & frm_ok & rdy_q;
   assign err_set[ERR_FRM] = frm_done & ~frm_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         rdy_q  <= 1'b0;
      end else begin
         if (frm_done && (!frm_ok || !rdy_q)) data_q <= frm_byte;
         if (frm_done && frm_ok && !rdy_q) rdy_q <= 1'b1;
         else if (rd_data) rdy_q <= 1'b0;
      end
   end

   for (genvar g = 0; g < ERR_CNT; g++) begin : g_err
      logic flag_q;
      logic seen_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flag_q <= 1'b0;
            seen_q <= 1'b0;
         end else if (err_set[g]) begin
            flag_q <= 1'b1;
         end else if (flag_q) begin
            if (wr_stat && !wr_bits[g] && seen_q) begin
               flag_q <= 1'b0;
               seen_q <= 1'b0;
            end else if (rd_stat) begin
               seen_q <= 1'b1;
            end
         end
      end
      assign err_q[g] = flag_q;
   end

endmodule

// File: rtl/async_rx_stat.sv
module async_rx_stat
   import arx_pkg::*;
#(
   parameter int OSR         = 16,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              os_tick,
   input  logic              rx_line,
   input  logic              rx_en,
   input  logic              two_stop,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic              bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata
);

   if (OSR < 4 || (OSR % 2) != 0) begin : g_bad_osr
      $error("OSR must be even and at least 4");
   end
   if (DATA_W < 3) begin : g_bad_width
      $error("DATA_W must hold the three status bits");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must lie in 0..4");
   end

   logic               line_s;
   logic               frm_done;
   logic               frm_ok;
   logic [DATA_W-1:0]  frm_byte;
   logic               rx_busy;
   logic [DATA_W-1:0]  data_q;
   logic               rdy_q;
   logic [ERR_CNT-1:0] err_q;
   logic               rd_data;
   logic               rd_stat;
   logic               wr_stat;
   logic [ERR_CNT-1:0] wr_bits;
   logic [DATA_W-1:0]  stat_word;

   arx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (rx_line),
      .dout (line_s)
   );

   arx_deframer #(.OSR(OSR), .DATA_W(DATA_W)) u_deframer (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (os_tick),
      .line    (line_s),
      .enable  (rx_en),
      .lock    (|err_q),
      .two_stop(two_stop),
      .done    (frm_done),
      .stop_ok (frm_ok),
      .byte_o  (frm_byte),
      .busy    (rx_busy)
   );

   assign rd_data = bus_sel & ~bus_wr & (bus_addr == ADDR_DATA);
   assign rd_stat = bus_sel & ~bus_wr & (bus_addr == ADDR_STAT);
   assign wr_stat = bus_sel &  bus_wr & (bus_addr == ADDR_STAT);
   assign wr_bits[ERR_OVR] = bus_wdata[STAT_OVR_BIT];
   assign wr_bits[ERR_FRM] = bus_wdata[STAT_FRM_BIT];

   arx_status #(.DATA_W(DATA_W)) u_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .frm_done(frm_done),
      .frm_ok  (frm_ok),
      .frm_byte(frm_byte),
      .rd_data (rd_data),
      .rd_stat (rd_stat),
      .wr_stat (wr_stat),
      .wr_bits (wr_bits),
      .data_q  (data_q),
      .rdy_q   (rdy_q),
      .err_q   (err_q)
   );

   always_comb begin
      stat_word               = '0;
      stat_word[STAT_RDY_BIT] = rdy_q;
      stat_word[STAT_OVR_BIT] = err_q[ERR_OVR];
      stat_word[STAT_FRM_BIT] = err_q[ERR_FRM];
   end

   assign bus_rdata = (bus_addr == ADDR_STAT) ? stat_word : data_q;

endmodule

// File: rtl/async_rx_stat_chk.sv
module async_rx_stat_chk
   import arx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_en,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic              bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              frm_done,
   input logic              frm_ok,
   input logic              rx_busy,
   input logic              rdy_q,
   input logic              ovr_q,
   input logic              frm_q,
   input logic [DATA_W-1:0] data_q
);

   logic stat_wr;
   assign stat_wr = bus_sel && bus_wr && (bus_addr == ADDR_STAT);

   AST_RDY_FROM_GOOD_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rdy_q) |-> $past(frm_done && frm_ok)); // R3

   AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_done && frm_ok && rdy_q) |=> $stable(data_q)); // R5

   AST_FRM_NO_RDY: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_done && !frm_ok && !rdy_q) |=> !rdy_q); // R6

   AST_ERR_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      ((ovr_q || frm_q) && !rx_busy) |=> !rx_busy); // R8

   AST_OVR_CLR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ovr_q) |-> $past(stat_wr && !bus_wdata[STAT_OVR_BIT])); // R9

   AST_FRM_CLR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(frm_q) |-> $past(stat_wr && !bus_wdata[STAT_FRM_BIT])); // R9

   AST_IDLE_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> !rx_busy); // R11

endmodule

bind async_rx_stat async_rx_stat_chk #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rx_en    (rx_en),
   .bus_sel  (bus_sel),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .bus_wdata(bus_wdata),
   .frm_done (frm_done),
   .frm_ok   (frm_ok),
   .rx_busy  (rx_busy),
   .rdy_q    (rdy_q),
   .ovr_q    (err_q[arx_pkg::ERR_OVR]),
   .frm_q    (err_q[arx_pkg::ERR_FRM]),
   .data_q   (data_q)
);

// File: tb/async_rx_stat_tb.sv
`timescale 1ns/1ps
module async_rx_stat_tb;

   localparam int OSR = 16;
   localparam int DW  = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          os_tick = 1'b1;
   logic          rx_line = 1'b1;
   logic          rx_en = 1'b1;
   logic          two_stop = 1'b0;
   logic          bus_sel = 1'b0;
   logic          bus_wr = 1'b0;
   logic          bus_addr = 1'b0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;

   int n_checks = 0;
   int n_fails  = 0;

   always #5 clk = ~clk;

   async_rx_stat #(.OSR(OSR), .DATA_W(DW), .SYNC_STAGES(2)) u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .os_tick  (os_tick),
      .rx_line  (rx_line),
      .rx_en    (rx_en),
      .two_stop (two_stop),
      .bus_sel  (bus_sel),
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata)
   );

   // vector: [11:4] byte, [3] two-stop mode, [2] first stop, [1] second stop, [0] spare
   localparam int NVEC = 6;
   localparam logic [11:0] VECS [NVEC] = '{
      {8'h55, 1'b0, 1'b1, 1'b1, 1'b0},
      {8'hA3, 1'b1, 1'b1, 1'b0, 1'b0},
      {8'h00, 1'b0, 1'b0, 1'b1, 1'b0},
      {8'hFF, 1'b1, 1'b1, 1'b1, 1'b0},
      {8'h81, 1'b1, 1'b0, 1'b1, 1'b0},
      {8'h3C, 1'b0, 1'b1, 1'b1, 1'b0}
   };

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: got %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic bus_read(input logic addr, output logic [DW-1:0] val);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = addr;
      #1 val = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic bus_write(input logic addr, input logic [DW-1:0] val);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = addr; bus_wdata = val;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic hold_line(input logic v, input int clocks);
      rx_line = v;
      repeat (clocks) @(negedge clk);
   endtask

   task automatic send_frame(input logic [7:0] b, input logic s1, input logic two, input logic s2);
      @(negedge clk);
      hold_line(1'b0, OSR);
      for (int i = 0; i < 8; i++) hold_line(b[i], OSR);
      hold_line(s1, OSR);
      if (two) hold_line(s2, OSR);
      hold_line(1'b1, 24);
   endtask

   task automatic finish_run;
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [DW-1:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      bus_read(1'b1, v); check("R1 status after reset", v, 8'h00);
      bus_read(1'b0, v); check("R1 data after reset", v, 8'h00);

      // table walk: R3 R6 R7 R4 R9
      for (int k = 0; k < NVEC; k++) begin
         logic [7:0] b;
         logic two, s1, s2;
         b = VECS[k][11:4]; two = VECS[k][3]; s1 = VECS[k][2]; s2 = VECS[k][1];
         two_stop = two;
         send_frame(b, s1, two, s2);
         bus_read(1'b1, v);
         check(s1 ? (two ? "R7 two-stop status" : "R3 good frame status") : "R6 framing status",
               v, s1 ? 8'h01 : 8'h04);
         bus_read(1'b0, v);
         check(s1 ? "R3 data LSB first" : "R6 data loaded on framing error", v, b);
         if (!s1) bus_write(1'b1, 8'h00);
         bus_read(1'b1, v);
         check(s1 ? "R4 data read clears ready" : "R9 framing cleared after read", v, 8'h00);
      end
      two_stop = 1'b0;

      // R2: short start glitch
      @(negedge clk);
      hold_line(1'b0, 4);
      hold_line(1'b1, 40);
      bus_read(1'b1, v); check("R2 glitch gives no frame", v, 8'h00);
      send_frame(8'h5A, 1'b1, 1'b0, 1'b1);
      bus_read(1'b0, v); check("R2 frame after glitch", v, 8'h5A);

      // R10: writes of ones ignored
      send_frame(8'h96, 1'b1, 1'b0, 1'b1);
      bus_write(1'b1, 8'hFF);
      bus_read(1'b1, v); check("R10 ones write ignored", v, 8'h01);
      bus_write(1'b1, 8'h00);
      bus_read(1'b1, v); check("R10 status write keeps ready", v, 8'h01);
      bus_read(1'b0, v); check("R4 data read", v, 8'h96);

      // R5: overrun
      send_frame(8'h11, 1'b1, 1'b0, 1'b1);
      send_frame(8'h22, 1'b1, 1'b0, 1'b1);
      bus_write(1'b1, 8'h00);
      bus_read(1'b1, v); check("R9 clear without read ignored", v, 8'h03);
      bus_read(1'b0, v); check("R5 earlier byte kept", v, 8'h11);
      // R8: lock
      send_frame(8'h33, 1'b1, 1'b0, 1'b1);
      bus_read(1'b1, v); check("R8 no frame while locked", v, 8'h02);
      bus_read(1'b0, v); check("R8 data unchanged while locked", v, 8'h11);
      bus_write(1'b1, 8'h00);
      bus_read(1'b1, v); check("R9 overrun cleared", v, 8'h00);
      send_frame(8'h44, 1'b1, 1'b0, 1'b1);
      bus_read(1'b1, v); check("R8 reception resumes", v, 8'h01);
      // R9: seen condition reset after clear
      send_frame(8'h55, 1'b1, 1'b0, 1'b1);
      bus_write(1'b1, 8'h00);
      bus_read(1'b1, v); check("R9 new overrun needs new read", v, 8'h03);
      bus_write(1'b1, 8'h00);
      bus_read(1'b0, v); check("R5 data kept", v, 8'h44);
      bus_read(1'b1, v); check("R9 overrun cleared again", v, 8'h00);

      // R11: disable keeps flags, blocks reception
      send_frame(8'h0F, 1'b0, 1'b0, 1'b1);
      @(negedge clk); rx_en = 1'b0;
      repeat (5) @(negedge clk);
      bus_read(1'b1, v); check("R11 framing flag kept when disabled", v, 8'h04);
      bus_write(1'b1, 8'h00);
      bus_read(1'b1, v); check("R11 clear while disabled", v, 8'h00);
      send_frame(8'hC3, 1'b1, 1'b0, 1'b1);
      bus_read(1'b1, v); check("R11 no frame when disabled", v, 8'h00);
      bus_read(1'b0, v); check("R11 data unchanged when disabled", v, 8'h0F);
      @(negedge clk); rx_en = 1'b1;
      send_frame(8'hE7, 1'b1, 1'b0, 1'b1);
      bus_read(1'b0, v); check("R11 frame after re-enable", v, 8'hE7);

      finish_run();
   end

endmodule